// File: doc/BRIEF.md
# Branch Target Buffer with Fetch Redirect Control

This block sits beside the instruction fetch stage. A small, fully associative table holds the addresses of branches that have been seen taken, each paired with the address that followed it. Every cycle the fetch PC is compared against all stored branch addresses within that cycle. On a match the stored address is offered as the next fetch address. Without a match, the next fetch address is the sequential one. Only taken branches are ever stored, so a match on its own means "predicted taken".

When a branch resolves in execute, the stage reports four things: its address, whether its fetch found a match, the next address that fetch used, and what the branch really did. The block then acts in one of three ways:
- It enters a taken branch that had no entry.
- It removes an entry whose prediction proved wrong.
- It leaves the table alone.

In the first two cases it raises a one-cycle redirect carrying the correct fetch address. It also holds a stall for a fixed penalty of cycles. The pipeline uses these to squash wrong-path work and restart fetch.

Top module: `btb_fetch_ctl`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `redirect` and `stall` are 0.
- R2: The lookup is combinational and compares all ADDR_W bits of `fetch_pc` with each valid stored address. On a match, `pred_hit`=1 and `pred_next_pc` is the stored target. Otherwise `pred_hit`=0 and `pred_next_pc`=`fetch_pc`+INSN_BYTES (4).
- R3: A resolve with `res_hit`=0 and `res_taken`=1 enters (`res_pc`, `res_target`) into the table. It also starts a redirect to `res_target`.
- R4: A resolve with `res_hit`=0 and `res_taken`=0 changes no entry and causes no redirect.
- R5: A resolve with `res_hit`=1 whose actual next address equals `res_pred_pc` changes no entry and causes no redirect. The actual next address is `res_target` if taken, otherwise `res_pc`+4.
- R6: A resolve with `res_hit`=1 whose actual next address differs from `res_pred_pc` removes the entry for `res_pc`. This holds whether the branch fell through or went to a different target. It also starts a redirect to the actual next address.
- R7: A new entry goes to the lowest-numbered invalid slot. When all slots are valid, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only when such a replacement happens.
- R8: An entry request for an address already in the table overwrites that entry's target. No second copy is ever made.
- R9: A table change made by a resolve is seen by lookups from the next cycle on. A lookup in the same cycle as the resolve sees the old contents.
- R10: A redirect event drives `redirect`=1 with `redirect_pc` for exactly the one cycle after the resolve. `stall`=1 for PENALTY (2) cycles starting with that cycle. A new event during a stall restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address of the instruction being fetched |
| pred_hit | output | 1 | Fetch address matched a stored branch |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | ADDR_W | Address of the resolving branch |
| res_hit | input | 1 | The branch matched the table when it was fetched |
| res_pred_pc | input | ADDR_W | Next address used at fetch for this branch |
| res_taken | input | 1 | Branch was actually taken |
| res_target | input | ADDR_W | Actual taken target |
| redirect | output | 1 | One-cycle fetch restart request |
| redirect_pc | output | ADDR_W | Correct fetch address, meaningful while `redirect` is 1 |
| stall | output | 1 | Penalty stall in progress |

## Verification
Lookup and table update can fall in the same cycle, and they may even touch the same address. The bench provokes this by presenting a branch's address on `fetch_pc` in the same cycle that the branch resolves as an entry or a removal. The lookup must report the old contents, and the following cycle must show the new ones.

A second collision is a new redirect event arriving while an earlier penalty stall is still counting down. The bench issues resolves on back-to-back cycles and judges that the stall restarts rather than adds or ends early. Both cases are compared each cycle against a behavioural model of the table and the stall timer.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_ENTER = 2'd1,
        ACT_DROP  = 2'd2
    } btb_act_e;
endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    input  btb_act_e          act,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] tgt;
        logic [IDX_W-1:0]               rr;
    } store_t;

    store_t s_d, s_q;
    logic [ENTRIES-1:0] lk_vec, up_vec;
    logic [IDX_W-1:0]   free_idx, match_idx;
    logic               have_free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_vec[g] = s_q.valid[g] && (s_q.tag[g] == lk_pc);
        assign up_vec[g] = s_q.valid[g] && (s_q.tag[g] == up_pc);
    end

    always_comb begin
        lk_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_vec[i]) lk_target = lk_target | s_q.tgt[i];
        end
    end
    assign lk_hit = |lk_vec;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        match_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!s_q.valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (up_vec[i]) match_idx = IDX_W'(i);
        end
    end

    always_comb begin
        s_d = s_q;
        case (act)
            ACT_ENTER: begin
                if (|up_vec) begin
                    s_d.tgt[match_idx] = up_target;
                end else if (have_free) begin
                    s_d.valid[free_idx] = 1'b1;
                    s_d.tag[free_idx]   = up_pc;
                    s_d.tgt[free_idx]   = up_target;
                end else begin
                    s_d.tag[s_q.rr] = up_pc;
                    s_d.tgt[s_q.rr] = up_target;
                    s_d.rr          = (s_q.rr == LAST_IDX) ? '0 : s_q.rr + 1'b1;
                end
            end
            ACT_DROP: s_d.valid = s_q.valid & ~up_vec;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(up_vec));

    // R9
    enter_seen_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ENTER) |=>
            (lk_pc != $past(up_pc)) || (lk_hit && lk_target == $past(up_target)));

    // R6
    drop_seen_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_DROP) |=> (lk_pc != $past(up_pc)) || !lk_hit);
endmodule

// File: rtl/btb_redirect.sv
module btb_redirect #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned PENALTY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev,
    input  logic [ADDR_W-1:0] ev_pc,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              stall
);
    localparam int unsigned CNT_W = $clog2(PENALTY + 1);

    typedef struct packed {
        logic              redir;
        logic [ADDR_W-1:0] pc;
        logic [CNT_W-1:0]  cnt;
    } redir_t;

    redir_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.redir = ev;
        if (ev) begin
            s_d.pc  = ev_pc;
            s_d.cnt = CNT_W'(PENALTY);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign redirect    = s_q.redir;
    assign redirect_pc = s_q.pc;
    assign stall       = (s_q.cnt != '0);

    logic [CNT_W:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (redirect) run_q <= (CNT_W+1)'(1);
        else if (stall)    run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    // R10
    redirect_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> stall);

    // R10
    stall_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect) |-> (run_q < (CNT_W+1)'(PENALTY)));

    // R10
    stall_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (run_q == (CNT_W+1)'(PENALTY)));
endmodule

// File: rtl/btb_fetch_ctl.sv
module btb_fetch_ctl
    import btb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ENTRIES    = 8,
    parameter int unsigned PENALTY    = 2,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_hit,
    input  logic [ADDR_W-1:0] res_pred_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              stall
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] lk_target, actual_pc;
    logic              lk_hit, ev;
    btb_act_e          act;

    always_comb begin
        actual_pc = res_taken ? res_target : (res_pc + STEP);
        act       = ACT_NONE;
        if (res_valid) begin
            if (!res_hit && res_taken)              act = ACT_ENTER;
            else if (res_hit && actual_pc != res_pred_pc) act = ACT_DROP;
        end
    end
    assign ev = (act != ACT_NONE);

    btb_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .act       (act),
        .up_pc     (res_pc),
        .up_target (res_target)
    );

    btb_redirect #(.ADDR_W(ADDR_W), .PENALTY(PENALTY)) u_redir (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .ev_pc       (actual_pc),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .stall       (stall)
    );

    assign pred_hit     = lk_hit;
    assign pred_next_pc = lk_hit ? lk_target : (fetch_pc + STEP);

    // R4
    nt_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit && !res_taken) |=> !redirect);

    // R5
    good_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && (res_taken ? res_target : res_pc + STEP) == res_pred_pc)
            |=> !redirect);
endmodule

// File: tb/btb_fetch_ctl_test.sv
module btb_fetch_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int PEN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_hit = 1'b0;
    logic [31:0] res_pred_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic        stall;

    btb_fetch_ctl #(.ADDR_W(32), .ENTRIES(N), .PENALTY(PEN), .INSN_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
        .pred_next_pc(pred_next_pc), .res_valid(res_valid), .res_pc(res_pc),
        .res_hit(res_hit), .res_pred_pc(res_pred_pc), .res_taken(res_taken),
        .res_target(res_target), .redirect(redirect), .redirect_pc(redirect_pc),
        .stall(stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          m_val [N];
    logic [31:0] m_tag [N];
    logic [31:0] m_tgt [N];
    int          m_rr = 0;
    bit          m_redir = 1'b0;
    logic [31:0] m_rpc = '0;
    int          m_left = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic model_update(input bit rv, input logic [31:0] rpc, input bit rh,
                                input logic [31:0] rpred, input bit rt,
                                input logic [31:0] rtgt);
        logic [31:0] actual;
        bit ev;
        int slot;
        ev = 1'b0;
        actual = rt ? rtgt : rpc + 32'd4;
        if (rv && !rh && rt) begin
            ev = 1'b1;
            slot = -1;
            for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == rpc) slot = i;
            if (slot >= 0) m_tgt[slot] = rtgt;
            else begin
                for (int i = N - 1; i >= 0; i--) if (!m_val[i]) slot = i;
                if (slot < 0) begin
                    slot = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_val[slot] = 1'b1;
                m_tag[slot] = rpc;
                m_tgt[slot] = rtgt;
            end
        end else if (rv && rh && actual != rpred) begin
            ev = 1'b1;
            for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == rpc) m_val[i] = 1'b0;
        end
        if (ev) begin
            m_redir = 1'b1;
            m_rpc   = actual;
            m_left  = PEN;
        end else begin
            m_redir = 1'b0;
            if (m_left > 0) m_left--;
        end
    endtask

    task automatic cyc(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                       input bit rh, input logic [31:0] rpred, input bit rt,
                       input logic [31:0] rtgt, input string tag);
        bit eh;
        logic [31:0] en;
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_hit = rh;
        res_pred_pc = rpred; res_taken = rt; res_target = rtgt;
        #1;
        eh = 1'b0;
        en = fpc + 32'd4;
        for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == fpc) begin
            eh = 1'b1;
            en = m_tgt[i];
        end
        chk(tag, "pred_hit", {31'd0, pred_hit}, {31'd0, eh});
        chk(tag, "pred_next_pc", pred_next_pc, en);
        chk(tag, "redirect", {31'd0, redirect}, {31'd0, m_redir});
        chk(tag, "stall", {31'd0, stall}, {31'd0, (m_left > 0)});
        if (m_redir) chk(tag, "redirect_pc", redirect_pc, m_rpc);
        @(posedge clk);
        model_update(rv, rpc, rh, rpred, rt, rtgt);
        @(negedge clk);
    endtask

    task automatic look(input logic [31:0] fpc, input string tag);
        cyc(fpc, 1'b0, '0, 1'b0, '0, 1'b0, '0, tag);
    endtask

    task automatic resolve(input logic [31:0] fpc, input logic [31:0] rpc, input bit rh,
                           input logic [31:0] rpred, input bit rt,
                           input logic [31:0] rtgt, input string tag);
        cyc(fpc, 1'b1, rpc, rh, rpred, rt, rtgt, tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset
        look(32'h1000, "R1");
        look(32'h0000_0000, "R1");
        // R3 + R9: enter A while fetching A in the same cycle
        resolve(32'h1000, 32'h1000, 1'b0, 32'h1004, 1'b1, 32'h2000, "R9");
        look(32'h1000, "R3");
        // R2: full-width compare, only the top bit differs
        look(32'h8000_1000, "R2");
        look(32'h1000, "R3");
        look(32'h1008, "R2");
        // R4: not-taken miss ignored
        resolve(32'h1100, 32'h1100, 1'b0, 32'h1104, 1'b0, 32'h0, "R4");
        look(32'h1100, "R4");
        look(32'h1100, "R4");
        // R5: correct hit, no action
        resolve(32'h1000, 32'h1000, 1'b1, 32'h2000, 1'b1, 32'h2000, "R5");
        look(32'h1000, "R5");
        // R6: hit, falls through -> drop, redirect to pc+4
        resolve(32'h1000, 32'h1000, 1'b1, 32'h2000, 1'b0, 32'h0, "R6");
        look(32'h1000, "R6");
        look(32'h1000, "R6");
        look(32'h1000, "R6");
        // R6: hit, taken to a different target -> drop
        resolve(32'h40, 32'h1000, 1'b0, 32'h1004, 1'b1, 32'h2000, "R3");
        look(32'h1000, "R3");
        look(32'h40, "R3");
        resolve(32'h1000, 32'h1000, 1'b1, 32'h2000, 1'b1, 32'h3000, "R6");
        look(32'h1000, "R6");
        look(32'h1000, "R6");
        look(32'h1000, "R6");
        // R7: fill, then round-robin replacement
        resolve(32'h0, 32'h100, 1'b0, 32'h104, 1'b1, 32'hA100, "R7");
        resolve(32'h0, 32'h200, 1'b0, 32'h204, 1'b1, 32'hA200, "R7");
        resolve(32'h0, 32'h300, 1'b0, 32'h304, 1'b1, 32'hA300, "R7");
        resolve(32'h0, 32'h400, 1'b0, 32'h404, 1'b1, 32'hA400, "R7");
        look(32'h100, "R7");
        look(32'h400, "R7");
        resolve(32'h100, 32'h500, 1'b0, 32'h504, 1'b1, 32'hA500, "R7");
        look(32'h100, "R7");
        look(32'h500, "R7");
        look(32'h200, "R7");
        resolve(32'h0, 32'h600, 1'b0, 32'h604, 1'b1, 32'hA600, "R7");
        look(32'h200, "R7");
        look(32'h600, "R7");
        // R7: a freed slot is filled before the pointer is used
        resolve(32'h300, 32'h300, 1'b1, 32'hA300, 1'b0, 32'h0, "R7");
        resolve(32'h0, 32'h700, 1'b0, 32'h704, 1'b1, 32'hA700, "R7");
        look(32'h700, "R7");
        look(32'h600, "R7");
        resolve(32'h0, 32'h800, 1'b0, 32'h804, 1'b1, 32'hA800, "R7");
        look(32'h700, "R7");
        look(32'h800, "R7");
        look(32'h400, "R7");
        // R8: re-entry of a present address overwrites, no duplicate
        resolve(32'h400, 32'h400, 1'b0, 32'h404, 1'b1, 32'h9000, "R8");
        look(32'h400, "R8");
        look(32'h500, "R8");
        look(32'h600, "R8");
        look(32'h800, "R8");
        // R10: back-to-back events restart the stall
        resolve(32'h0, 32'h900, 1'b0, 32'h904, 1'b1, 32'hB900, "R10");
        resolve(32'h0, 32'h500, 1'b1, 32'hA500, 1'b0, 32'h0, "R10");
        look(32'h0, "R10");
        look(32'h0, "R10");
        look(32'h0, "R10");
        look(32'h500, "R10");
        // R10: event during the second stall cycle
        resolve(32'h0, 32'hC00, 1'b0, 32'hC04, 1'b1, 32'hCC00, "R10");
        look(32'h0, "R10");
        resolve(32'h0, 32'hD00, 1'b0, 32'hD04, 1'b1, 32'hDD00, "R10");
        look(32'h0, "R10");
        look(32'h0, "R10");
        look(32'h0, "R10");
        look(32'hD00, "R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule